// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute stage of a 32-bit load/store RISC pipeline. Each cycle it receives an already-split instruction: the 6-bit primary opcode, the 6-bit function code, the 5-bit shift count and the 16-bit immediate. It also receives the two operands read from the register file. It decodes the operation and computes a 32-bit result. One clock edge later it presents that result with a write-enable for the writeback stage.

The stage covers the register-register operations: add, subtract, the three bitwise logic operations, the three shifts and the two compares. It also covers the immediate forms: add, signed and unsigned compare, AND, OR and upper-half load. Any encoding outside that set produces a zero result with the write-enable low, so the writeback stage leaves the register file untouched. Arithmetic overflow raises no trap, memory access is not handled here, and branch resolution is not handled here.

Top module: `exec_unit`

## Requirements
- R1: With opcode 0x00, function 0x20 gives srcA + srcB and function 0x22 gives srcA - srcB, both wrapping modulo 2^32 with no overflow signalling.
- R2: With opcode 0x00, function 0x24 gives srcA AND srcB, 0x25 gives srcA OR srcB, and 0x27 gives the bitwise inverse of (srcA OR srcB).
- R3: With opcode 0x00, functions 0x00, 0x02 and 0x03 shift srcB by shamt. 0x00 shifts left, 0x02 shifts right filling with zeros, and 0x03 shifts right filling with copies of srcB bit 31.
- R4: With opcode 0x00, function 0x2a gives 1 when srcA < srcB as two's-complement values and 0 otherwise. Function 0x2b makes the same comparison as unsigned values.
- R5: Opcode 0x08 gives srcA plus the immediate sign-extended to 32 bits.
- R6: Opcode 0x0a gives 1 when srcA is below the sign-extended immediate, comparing as signed values. Opcode 0x0b sign-extends the immediate the same way and compares as unsigned values. Both give 0 otherwise.
- R7: Opcode 0x0c gives srcA AND the zero-extended immediate, and opcode 0x0d gives srcA OR the zero-extended immediate.
- R8: Opcode 0x0f gives the immediate in bits 31..16 and zeros in bits 15..0, independent of srcA and srcB.
- R9: Every opcode and function pair listed in R1 to R8 raises wrEn. Any other pair, including opcode 0x00 with an unlisted function code, gives wrEn = 0 and result = 0.
- R10: result and wrEn update on the rising clock edge one cycle after the inputs are presented. A synchronous active-high rst clears both at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field, used when opcode is 0 |
| shamt | input | 5 | Shift count field |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand, the shifted value for shifts |
| imm | input | 16 | Immediate field |
| result | output | 32 | Registered result |
| wrEn | output | 1 | Registered write-enable for the destination register |

## Verification
The bench builds the block with its default widths, a 32-bit datapath and a 16-bit immediate. At those widths the sign bit sits at bit 31 and the upper-half load fills exactly bits 31..16. The operand values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF therefore exercise signed wrap, sign fill and the case where the signed and unsigned compares disagree. The random operand pool is biased toward these values, and an immediate of 0xFFFF shows the difference between sign-extended and zero-extended forms.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0a;
  localparam logic [5:0] OPC_SLTIU = 6'h0b;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_LUI   = 6'h0f;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2a;
  localparam logic [5:0] FN_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluOpE;

  typedef struct packed {
    aluOpE aluOp;
    logic  useImm;
    logic  immZext;
    logic  writeOk;
  } ctrlStrobesT;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctrlStrobesT strobes
);

  always_comb begin
    strobes = '{aluOp: ALU_NONE, useImm: 1'b0, immZext: 1'b0, writeOk: 1'b0};
    unique case (opcode)
      OPC_RTYPE: begin
        strobes.writeOk = 1'b1;
        case (funct)
          FN_ADD:  strobes.aluOp = ALU_ADD;
          FN_SUB:  strobes.aluOp = ALU_SUB;
          FN_AND:  strobes.aluOp = ALU_AND;
          FN_OR:   strobes.aluOp = ALU_OR;
          FN_NOR:  strobes.aluOp = ALU_NOR;
          FN_SLT:  strobes.aluOp = ALU_SLT;
          FN_SLTU: strobes.aluOp = ALU_SLTU;
          FN_SLL:  strobes.aluOp = ALU_SLL;
          FN_SRL:  strobes.aluOp = ALU_SRL;
          FN_SRA:  strobes.aluOp = ALU_SRA;
          default: begin
            strobes.aluOp   = ALU_NONE;
            strobes.writeOk = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin
        strobes.aluOp = ALU_ADD; strobes.useImm = 1'b1; strobes.writeOk = 1'b1;
      end
      OPC_SLTI: begin
        strobes.aluOp = ALU_SLT; strobes.useImm = 1'b1; strobes.writeOk = 1'b1;
      end
      OPC_SLTIU: begin
        strobes.aluOp = ALU_SLTU; strobes.useImm = 1'b1; strobes.writeOk = 1'b1;
      end
      OPC_ANDI: begin
        strobes.aluOp = ALU_AND; strobes.useImm = 1'b1;
        strobes.immZext = 1'b1; strobes.writeOk = 1'b1;
      end
      OPC_ORI: begin
        strobes.aluOp = ALU_OR; strobes.useImm = 1'b1;
        strobes.immZext = 1'b1; strobes.writeOk = 1'b1;
      end
      OPC_LUI: begin
        strobes.aluOp = ALU_LUI; strobes.useImm = 1'b1; strobes.writeOk = 1'b1;
      end
      default: ;
    endcase
  end

  // Zero extension only ever accompanies the two logic immediates
  always_comb begin
    AST_ZEXT_LOGIC_ONLY: assert (!strobes.immZext ||
      strobes.aluOp == ALU_AND || strobes.aluOp == ALU_OR); // R7
    AST_NONE_NO_WRITE: assert (strobes.writeOk == (strobes.aluOp != ALU_NONE)); // R9
  end

endmodule

// File: rtl/exec_dpath.sv
module exec_dpath
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int EXT_W = DATA_W - IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobesT       strobes,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              wrEn
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] sumOut;
  logic [DATA_W-1:0] diffOut;
  logic              ltSigned;
  logic              ltUnsigned;

  assign immExt = strobes.immZext ? {{EXT_W{1'b0}}, imm}
                                  : {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opB    = strobes.useImm ? immExt : srcB;

  assign sumOut     = srcA + opB;
  assign diffOut    = srcA - opB;
  assign ltSigned   = $signed(srcA) < $signed(opB);
  assign ltUnsigned = srcA < opB;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_ADD:  aluOut = sumOut;
      ALU_SUB:  aluOut = diffOut;
      ALU_AND:  aluOut = srcA & opB;
      ALU_OR:   aluOut = srcA | opB;
      ALU_NOR:  aluOut = ~(srcA | opB);
      ALU_SLT:  aluOut = {{(DATA_W-1){1'b0}}, ltSigned};
      ALU_SLTU: aluOut = {{(DATA_W-1){1'b0}}, ltUnsigned};
      ALU_SLL:  aluOut = srcB << shamt;
      ALU_SRL:  aluOut = srcB >> shamt;
      ALU_SRA:  aluOut = DATA_W'($signed(srcB) >>> shamt);
      ALU_LUI:  aluOut = {imm, {EXT_W{1'b0}}};
      default:  aluOut = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wrEn   <= 1'b0;
    end else begin
      wrEn   <= strobes.writeOk;
      result <= strobes.writeOk ? aluOut : '0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && !wrEn)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> result == '0); // R9
  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (strobes.aluOp == ALU_SLT || strobes.aluOp == ALU_SLTU)
      |=> result[DATA_W-1:1] == '0); // R4
  AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobes.aluOp == ALU_LUI |=> result[EXT_W-1:0] == '0); // R8
  AST_SRL_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobes.aluOp == ALU_SRL && shamt != '0) |=> !result[DATA_W-1]); // R3
  AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    strobes.aluOp == ALU_SRA |=> result[DATA_W-1] == $past(srcB[DATA_W-1])); // R3

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              wrEn
);

  ctrlStrobesT strobes;

  exec_ctrl u_ctrl (
    .opcode  (opcode),
    .funct   (funct),
    .strobes (strobes)
  );

  exec_dpath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .shamt   (shamt),
    .srcA    (srcA),
    .srcB    (srcB),
    .imm     (imm),
    .result  (result),
    .wrEn    (wrEn)
  );

endmodule

// File: tb/sim_exec_unit.sv
`timescale 1ns/1ps
module sim_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        wrEn;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  exec_unit u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .shamt(shamt),
    .srcA(srcA), .srcB(srcB), .imm(imm), .result(result), .wrEn(wrEn)
  );

  // Expected {wrEn, result} from the requirement text
  function automatic logic [32:0] model(input logic [5:0] op, input logic [5:0] fn,
                                        input logic [4:0] sh, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im);
    logic [31:0] sx = {{16{im[15]}}, im};
    logic [31:0] zx = {16'h0, im};
    case (op)
      6'h00: case (fn)
        6'h20: return {1'b1, a + b};
        6'h22: return {1'b1, a - b};
        6'h24: return {1'b1, a & b};
        6'h25: return {1'b1, a | b};
        6'h27: return {1'b1, ~(a | b)};
        6'h2a: return {1'b1, 31'h0, $signed(a) < $signed(b)};
        6'h2b: return {1'b1, 31'h0, a < b};
        6'h00: return {1'b1, b << sh};
        6'h02: return {1'b1, b >> sh};
        6'h03: return {1'b1, 32'($signed(b) >>> sh)};
        default: return 33'h0;
      endcase
      6'h08: return {1'b1, a + sx};
      6'h0a: return {1'b1, 31'h0, $signed(a) < $signed(sx)};
      6'h0b: return {1'b1, 31'h0, a < sx};
      6'h0c: return {1'b1, a & zx};
      6'h0d: return {1'b1, a | zx};
      6'h0f: return {1'b1, im, 16'h0};
      default: return 33'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'h00) begin
      case (fn)
        6'h20, 6'h22: return "R1";
        6'h24, 6'h25, 6'h27: return "R2";
        6'h00, 6'h02, 6'h03: return "R3";
        6'h2a, 6'h2b: return "R4";
        default: return "R9";
      endcase
    end
    case (op)
      6'h08: return "R5";
      6'h0a, 6'h0b: return "R6";
      6'h0c, 6'h0d: return "R7";
      6'h0f: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] expRes, input logic expWe);
    testCnt++;
    if (result !== expRes || wrEn !== expWe) begin
      failCnt++;
      $display("FAIL %s: result=%08h wrEn=%0b expected result=%08h wrEn=%0b",
               tag, result, wrEn, expRes, expWe);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    @(negedge clk);
    opcode = op; funct = fn; shamt = sh; srcA = a; srcB = b; imm = im;
    @(posedge clk);
    #1;
  endtask

  task automatic directed(input string tag, input logic [5:0] op, input logic [5:0] fn,
                          input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [31:0] expRes, input logic expWe);
    apply(op, fn, sh, a, b, im);
    check(tag, expRes, expWe);
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  localparam logic [11:0] OPS [17] = '{
    {6'h00,6'h20}, {6'h00,6'h22}, {6'h00,6'h24}, {6'h00,6'h25}, {6'h00,6'h27},
    {6'h00,6'h00}, {6'h00,6'h02}, {6'h00,6'h03}, {6'h00,6'h2a}, {6'h00,6'h2b},
    {6'h08,6'h00}, {6'h0a,6'h00}, {6'h0b,6'h00}, {6'h0c,6'h00}, {6'h0d,6'h00},
    {6'h0f,6'h00}, {6'h3f,6'h3f}
  };

  initial begin
    #1_000_000;
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: result=%08h wrEn=%0b expected run completion", result, wrEn);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250301));
    // R10: reset state
    apply(6'h00, 6'h20, 5'd0, 32'h5, 32'h6, 16'h0);
    check("R10 reset", 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0;

    directed("R1 add wrap", 6'h00, 6'h20, 0, 32'h7FFF_FFFF, 32'h1, 0, 32'h8000_0000, 1);
    directed("R1 sub wrap", 6'h00, 6'h22, 0, 32'h0, 32'h1, 0, 32'hFFFF_FFFF, 1);
    directed("R2 nor", 6'h00, 6'h27, 0, 32'h0, 32'h0, 0, 32'hFFFF_FFFF, 1);
    directed("R2 and", 6'h00, 6'h24, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 32'h00F0_1200, 1);
    directed("R3 srl", 6'h00, 6'h02, 4, 32'h0, 32'h8000_0000, 0, 32'h0800_0000, 1);
    directed("R3 sra", 6'h00, 6'h03, 4, 32'h0, 32'h8000_0000, 0, 32'hF800_0000, 1);
    directed("R3 sll", 6'h00, 6'h00, 31, 32'h0, 32'h3, 0, 32'h8000_0000, 1);
    directed("R4 slt", 6'h00, 6'h2a, 0, 32'hFFFF_FFFF, 32'h1, 0, 32'h1, 1);
    directed("R4 sltu", 6'h00, 6'h2b, 0, 32'hFFFF_FFFF, 32'h1, 0, 32'h0, 1);
    directed("R5 addi neg", 6'h08, 6'h00, 0, 32'h5, 32'h0, 16'hFFFF, 32'h4, 1);
    directed("R6 slti", 6'h0a, 6'h00, 0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 32'h1, 1);
    directed("R6 sltiu", 6'h0b, 6'h00, 0, 32'h5, 32'h0, 16'hFFFF, 32'h1, 1);
    directed("R7 andi", 6'h0c, 6'h00, 0, 32'h1234_5678, 32'h0, 16'hFF00, 32'h0000_5600, 1);
    directed("R7 ori", 6'h0d, 6'h00, 0, 32'hFFFF_0000, 32'h0, 16'h8001, 32'hFFFF_8001, 1);
    directed("R8 lui", 6'h0f, 6'h00, 0, 32'hDEAD_BEEF, 32'h1234_5678, 16'hFFFF, 32'hFFFF_0000, 1);
    directed("R9 bad opcode", 6'h3f, 6'h20, 0, 32'h1, 32'h1, 16'h1, 32'h0, 0);
    directed("R9 bad funct", 6'h00, 6'h21, 0, 32'h1, 32'h1, 16'h1, 32'h0, 0);

    // R10: reset in the middle of traffic
    @(negedge clk);
    opcode = 6'h00; funct = 6'h20; srcA = 32'h10; srcB = 32'h20; rst = 1'b1;
    @(posedge clk); #1;
    check("R10 mid reset", 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R10 latency", 32'h30, 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [5:0] op, fn;
      logic [4:0] sh;
      logic [31:0] a, b;
      logic [15:0] im;
      logic [32:0] exp;
      int k = $urandom_range(0, 16);
      op = OPS[k][11:6]; fn = OPS[k][5:0];
      if (k == 16) begin op = 6'($urandom); fn = 6'($urandom); end
      sh = 5'($urandom); a = pickVal(); b = pickVal();
      im = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      exp = model(op, fn, sh, a, b, im);
      apply(op, fn, sh, a, b, im);
      check(tagOf(op, fn), exp[31:0], exp[32]);
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule